// File: doc/BRIEF.md
# I2C Bus Observer with Event Timestamps

This block listens to the clock and data lines of an I2C bus and never drives them. It samples both lines in the core clock domain, cleans them with a short agreement filter, and rebuilds the bus traffic as a stream of events. Each event is a start, a repeated start, a stop, or a completed data byte together with its acknowledge bit. Every event is stamped with the value of a free-running cycle counter, so software downstream can measure gaps between transfers.

Framing is found by turning every data-line transition into a one-cycle change pulse. The pulse is the XOR of the filtered data line and a one-cycle-delayed copy of it. A pulse only counts when the clock line is high. Data-line activity during the clock-low phase therefore never reaches the event path. Events queue in a small first-word-fall-through FIFO that drives a valid/ready stream. When the FIFO is full, a sticky overflow flag records the lost event.

Top module: `i2c_bus_observer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ev_valid` and `ovf_flag` are 0.
- R2: A falling data line while the clock line is high, with no frame open, emits an event of kind 0 (start) and opens a frame.
- R3: A falling data line while the clock line is high, with a frame open, emits an event of kind 1 (repeated start).
- R4: A rising data line while the clock line is high emits an event of kind 2 (stop) and closes the frame.
- R5: Inside a frame, 8 rising clock edges shift a byte MSB first. The 9th rising edge samples the acknowledge bit into `ev_nack` (0 = acknowledged) and emits kind 3 with the byte on `ev_byte`. Events of kinds 0 to 2 carry `ev_byte` = 0 and `ev_nack` = 0.
- R6: Data-line changes while the clock line is low emit no event and do not disturb the byte being shifted.
- R7: A pulse on either line that lasts fewer than FILT_LEN core cycles produces no event.
- R8: A start or stop that arrives before the 9th clock edge of a byte discards the partial byte, and no byte event is emitted for it.
- R9: `ev_time` holds the TS_W-bit wrapping cycle count at the moment an event is detected. The difference between two events' stamps equals the spacing in core cycles of the line changes that caused them.
- R10: Events leave in arrival order. While `ev_valid` is 1 and `ev_ready` is 0, the event on the outputs is held unchanged.
- R11: An event that arrives while the FIFO is full is dropped and sets `ovf_flag`. The flag stays at 1 until a one-cycle `ovf_clear` pulse. If a drop happens in the same cycle as the clear, the set wins.
- R12: A data-line change only two core cycles ahead of a rising clock edge is still sampled correctly into the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| ev_valid | output | 1 | An event is on the outputs |
| ev_ready | input | 1 | Consumer takes the event |
| ev_kind | output | 2 | 0 start, 1 repeated start, 2 stop, 3 byte |
| ev_byte | output | 8 | Received byte (kind 3), else 0 |
| ev_nack | output | 1 | Acknowledge bit of the byte, 1 = not acknowledged |
| ev_time | output | TS_W | Cycle stamp of detection |
| ovf_flag | output | 1 | Sticky lost-event flag |
| ovf_clear | input | 1 | Pulse that clears the overflow flag |

## Verification
The bench focuses on the cases that separate framing from data. Data-line toggling in the clock-low phase would create false starts or stops if the clock gate were missing. A stop or repeated start in the middle of a byte would leak a garbage byte if the bit counter were not reset. A data bit set up only two cycles before the clock edge would be sampled stale if the two lines had different pipeline depths. Short glitches on the lines are checked to produce nothing. Timestamp deltas are compared with the cycle spacing of the driven edges, which catches an off-by-one in stamp capture. A burst that fills the FIFO checks that the output holds under backpressure, that the excess is dropped in order, and that the overflow flag survives draining until it is cleared.

// File: rtl/i2c_obs_pkg.sv
package i2c_obs_pkg;
   typedef enum logic [1:0] {
      EV_START   = 2'd0,
      EV_RESTART = 2'd1,
      EV_STOP    = 2'd2,
      EV_BYTE    = 2'd3
   } ev_kind_e;
endpackage

// File: rtl/i2c_obs_line_cond.sv
// Synchronizer followed by an agreement filter: the clean output only
// moves once FILT_LEN consecutive synchronized samples agree.
module i2c_obs_line_cond #(
   parameter int STAGES   = 2,
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   logic [STAGES-1:0] sync_q;
   logic              synced;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[STAGES-2:0], raw};
   end
   assign synced = sync_q[STAGES-1];

   generate
      if (FILT_LEN <= 1) begin : g_nofilt
         always_ff @(posedge clk) begin
            if (!rst_n) clean <= 1'b1;
            else        clean <= synced;
         end
      end else begin : g_filt
         logic [FILT_LEN-1:0] hist_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_q <= '1;
               clean  <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], synced};
               if (&hist_q)       clean <= 1'b1;
               else if (~|hist_q) clean <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_obs_decoder.sv
// Turns clean bus lines into framing and byte events, each with a stamp.
module i2c_obs_decoder
   import i2c_obs_pkg::*;
#(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl,
   input  logic            sda,
   input  logic [TS_W-1:0] ts,
   output logic            push,
   output logic [1:0]      kind,
   output logic [7:0]      data,
   output logic            nack,
   output logic [TS_W-1:0] stamp
);
   localparam int BITS = 8;

   logic       scl_d, sda_d;
   logic       in_frame;
   logic [3:0] bit_cnt;
   logic [BITS-1:0] shift_q;
   logic       sda_pulse, framing, scl_rise;

   // Change pulse from current vs delayed copy, gated by a steady-high clock
   assign sda_pulse = sda ^ sda_d;
   assign framing   = sda_pulse & scl & scl_d;
   assign scl_rise  = scl & ~scl_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
         in_frame <= 1'b0;
         bit_cnt  <= '0;
         shift_q  <= '0;
         push     <= 1'b0;
         kind     <= EV_START;
         data     <= '0;
         nack     <= 1'b0;
         stamp    <= '0;
      end else begin
         scl_d <= scl;
         sda_d <= sda;
         push  <= 1'b0;
         if (framing) begin
            push    <= 1'b1;
            data    <= '0;
            nack    <= 1'b0;
            stamp   <= ts;
            bit_cnt <= '0;
            if (!sda) begin
               kind     <= in_frame ? EV_RESTART : EV_START;
               in_frame <= 1'b1;
            end else begin
               kind     <= EV_STOP;
               in_frame <= 1'b0;
            end
         end else if (scl_rise && in_frame) begin
            if (bit_cnt == 4'(BITS)) begin
               push    <= 1'b1;
               kind    <= EV_BYTE;
               data    <= shift_q;
               nack    <= sda;
               stamp   <= ts;
               bit_cnt <= '0;
            end else begin
               shift_q <= {shift_q[BITS-2:0], sda};
               bit_cnt <= bit_cnt + 4'd1;
            end
         end
      end
   end
endmodule

// File: rtl/i2c_obs_fifo.sv
// First-word-fall-through event queue with a sticky drop flag.
module i2c_obs_fifo #(
   parameter int W     = 43,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         not_empty,
   input  logic         ovf_clear,
   output logic         ovf
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_q, rd_q, count;
   logic         full, do_push, do_pop;

   assign count     = wr_q - rd_q;
   assign full      = (count == (AW+1)'(DEPTH));
   assign not_empty = (count != '0);
   assign do_push   = push & ~full;
   assign do_pop    = pop & not_empty;
   assign dout      = mem[rd_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q[AW-1:0]] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
         ovf  <= 1'b0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         if (push && full) ovf <= 1'b1;
         else if (ovf_clear) ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_bus_observer.sv
module i2c_bus_observer
   import i2c_obs_pkg::*;
#(
   parameter int TS_W        = 32,
   parameter int FIFO_DEPTH  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_in,
   input  logic            sda_in,
   output logic            ev_valid,
   input  logic            ev_ready,
   output logic [1:0]      ev_kind,
   output logic [7:0]      ev_byte,
   output logic            ev_nack,
   output logic [TS_W-1:0] ev_time,
   output logic            ovf_flag,
   input  logic            ovf_clear
);
   localparam int ENTRY_W = 2 + 8 + 1 + TS_W;

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TS_W < 8 || TS_W > 64) begin : g_bad_ts
      $error("TS_W must lie in 8..64");
   end

   logic scl_c, sda_c;
   logic [TS_W-1:0] ts_q;
   logic            d_push, d_nack;
   logic [1:0]      d_kind;
   logic [7:0]      d_data;
   logic [TS_W-1:0] d_stamp;
   logic [ENTRY_W-1:0] q_din, q_dout;

   i2c_obs_line_cond #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_cond (
      .clk(clk), .rst_n(rst_n), .raw(scl_in), .clean(scl_c));
   i2c_obs_line_cond #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_cond (
      .clk(clk), .rst_n(rst_n), .raw(sda_in), .clean(sda_c));

   always_ff @(posedge clk) begin
      if (!rst_n) ts_q <= '0;
      else        ts_q <= ts_q + 1'b1;
   end

   i2c_obs_decoder #(.TS_W(TS_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .scl(scl_c), .sda(sda_c), .ts(ts_q),
      .push(d_push), .kind(d_kind), .data(d_data), .nack(d_nack), .stamp(d_stamp));

   assign q_din = {d_kind, d_data, d_nack, d_stamp};

   i2c_obs_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(d_push), .din(q_din),
      .pop(ev_ready), .dout(q_dout), .not_empty(ev_valid),
      .ovf_clear(ovf_clear), .ovf(ovf_flag));

   assign {ev_kind, ev_byte, ev_nack, ev_time} = q_dout;
endmodule

// File: rtl/i2c_bus_observer_chk.sv
module i2c_bus_observer_chk #(
   parameter int TS_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ev_valid,
   input logic            ev_ready,
   input logic [1:0]      ev_kind,
   input logic [7:0]      ev_byte,
   input logic            ev_nack,
   input logic [TS_W-1:0] ev_time,
   input logic            ovf_flag,
   input logic            ovf_clear
);
   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!ev_valid && !ovf_flag));

   // R10
   hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_kind) && $stable(ev_byte)
                                   && $stable(ev_nack) && $stable(ev_time)));

   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clear) |=> ovf_flag);

   // R11
   ovf_backlog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(ev_valid));

   // R5
   framing_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind != 2'd3) |-> (ev_byte == 8'd0 && !ev_nack));
endmodule

bind i2c_bus_observer i2c_bus_observer_chk #(.TS_W(TS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
   .ev_kind(ev_kind), .ev_byte(ev_byte), .ev_nack(ev_nack), .ev_time(ev_time),
   .ovf_flag(ovf_flag), .ovf_clear(ovf_clear));

// File: tb/i2c_bus_observer_bench.sv
`timescale 1ns/1ps
module i2c_bus_observer_bench;
   localparam int TS_W = 32;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic ev_ready = 1'b1, ovf_clear = 1'b0;
   logic ev_valid, ev_nack, ovf_flag;
   logic [1:0] ev_kind;
   logic [7:0] ev_byte;
   logic [TS_W-1:0] ev_time;

   int checks = 0, fails = 0;
   int cyc = 0;
   bit done = 0;

   logic [1:0]      cap_kind [64];
   logic [7:0]      cap_byte [64];
   logic            cap_nack [64];
   logic [TS_W-1:0] cap_time [64];
   int ev_cnt = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   i2c_bus_observer #(.TS_W(TS_W), .FIFO_DEPTH(DEPTH)) u_i2c_bus_observer (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
      .ev_byte(ev_byte), .ev_nack(ev_nack), .ev_time(ev_time),
      .ovf_flag(ovf_flag), .ovf_clear(ovf_clear));

   always @(negedge clk) begin
      if (rst_n && ev_valid && ev_ready && ev_cnt < 64) begin
         cap_kind[ev_cnt] = ev_kind;
         cap_byte[ev_cnt] = ev_byte;
         cap_nack[ev_cnt] = ev_nack;
         cap_time[ev_cnt] = ev_time;
         ev_cnt = ev_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic bus_start();
      sda = 1'b0; step(8);
   endtask
   task automatic bus_stop();
      scl = 1'b0; step(3); sda = 1'b0; step(5); scl = 1'b1; step(8); sda = 1'b1; step(8);
   endtask
   task automatic bus_restart();
      scl = 1'b0; step(3); sda = 1'b1; step(5); scl = 1'b1; step(8); sda = 1'b0; step(8);
   endtask
   task automatic bus_bits(input logic [7:0] v, input int n, input int setup, input bit noisy);
      for (int i = 7; i > 7 - n; i--) begin
         scl = 1'b0; step(3);
         if (noisy) begin sda = ~v[i]; step(4); sda = v[i]; step(4); sda = ~v[i]; step(4); end
         sda = v[i]; step(setup);
         scl = 1'b1; step(8);
      end
   endtask
   task automatic bus_byte(input logic [7:0] v, input bit nk, input int setup, input bit noisy);
      bus_bits(v, 8, setup, noisy);
      scl = 1'b0; step(3); sda = nk; step(setup); scl = 1'b1; step(8);
   endtask

   task automatic expect_ev(input int idx, input logic [1:0] k, input logic [7:0] b,
                            input logic n, input string req);
      chk(cap_kind[idx] == k, {req, " kind"}, cap_kind[idx], k);
      chk(cap_byte[idx] == b, {req, " byte"}, cap_byte[idx], b);
      chk(cap_nack[idx] == n, {req, " nack"}, cap_nack[idx], n);
   endtask

   task automatic t_reset();
      chk(ev_valid == 1'b0, "R1 valid in reset", ev_valid, 0);
      chk(ovf_flag == 1'b0, "R1 ovf in reset", ovf_flag, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk(ev_valid == 1'b0, "R1 valid after reset", ev_valid, 0);
      chk(ovf_flag == 1'b0, "R1 ovf after reset", ovf_flag, 0);
      step(10);
   endtask

   task automatic t_byte();
      int b = ev_cnt;
      bus_start(); bus_byte(8'hA5, 1'b0, 5, 1'b0); bus_stop(); step(20);
      chk(ev_cnt - b == 3, "R2 R4 R5 event count", ev_cnt - b, 3);
      expect_ev(b,   2'd0, 8'h00, 1'b0, "R2 start");
      expect_ev(b+1, 2'd3, 8'hA5, 1'b0, "R5 byte");
      expect_ev(b+2, 2'd2, 8'h00, 1'b0, "R4 stop");
   endtask

   task automatic t_restart();
      int b = ev_cnt;
      bus_start(); bus_byte(8'h3C, 1'b1, 5, 1'b0);
      bus_restart(); bus_byte(8'hC3, 1'b0, 5, 1'b0); bus_stop(); step(20);
      chk(ev_cnt - b == 5, "R3 event count", ev_cnt - b, 5);
      expect_ev(b+1, 2'd3, 8'h3C, 1'b1, "R5 nack byte");
      expect_ev(b+2, 2'd1, 8'h00, 1'b0, "R3 restart");
      expect_ev(b+3, 2'd3, 8'hC3, 1'b0, "R3 byte after restart");
   endtask

   task automatic t_low_toggle();
      int b = ev_cnt;
      scl = 1'b0; step(3);
      for (int i = 0; i < 4; i++) begin sda = ~sda; step(5); end
      sda = 1'b1; step(5); scl = 1'b1; step(20);
      chk(ev_cnt == b, "R6 idle low-phase toggles", ev_cnt - b, 0);
      bus_start(); bus_byte(8'h96, 1'b0, 5, 1'b1); bus_stop(); step(20);
      chk(ev_cnt - b == 3, "R6 noisy frame count", ev_cnt - b, 3);
      expect_ev(b+1, 2'd3, 8'h96, 1'b0, "R6 noisy byte");
   endtask

   task automatic t_glitch();
      int b = ev_cnt;
      sda = 1'b0; step(1); sda = 1'b1; step(10);
      sda = 1'b0; step(2); sda = 1'b1; step(10);
      scl = 1'b0; step(2); scl = 1'b1; step(10);
      chk(ev_cnt == b, "R7 glitches", ev_cnt - b, 0);
   endtask

   task automatic t_abort();
      int b = ev_cnt;
      bus_start(); bus_bits(8'hFF, 4, 5, 1'b0); bus_stop(); step(20);
      chk(ev_cnt - b == 2, "R8 stop abort count", ev_cnt - b, 2);
      expect_ev(b+1, 2'd2, 8'h00, 1'b0, "R8 stop after partial");
      b = ev_cnt;
      bus_start(); bus_bits(8'h00, 3, 5, 1'b0); bus_restart();
      bus_byte(8'h81, 1'b1, 5, 1'b0); bus_stop(); step(20);
      chk(ev_cnt - b == 4, "R8 restart abort count", ev_cnt - b, 4);
      expect_ev(b+1, 2'd1, 8'h00, 1'b0, "R8 restart after partial");
      expect_ev(b+2, 2'd3, 8'h81, 1'b1, "R8 clean byte after abort");
   endtask

   task automatic t_tight();
      int b = ev_cnt;
      bus_start(); bus_byte(8'h5A, 1'b1, 2, 1'b0); bus_stop(); step(20);
      chk(ev_cnt - b == 3, "R12 count", ev_cnt - b, 3);
      expect_ev(b+1, 2'd3, 8'h5A, 1'b1, "R12 tight setup byte");
   endtask

   task automatic t_time();
      int b = ev_cnt;
      int c0, c1;
      c0 = cyc; sda = 1'b0; step(37);
      scl = 1'b0; step(3); scl = 1'b1; step(8);
      c1 = cyc; sda = 1'b1; step(20);
      chk(ev_cnt - b == 2, "R9 count", ev_cnt - b, 2);
      chk(cap_time[b+1] - cap_time[b] == TS_W'(c1 - c0), "R9 stamp delta",
          cap_time[b+1] - cap_time[b], c1 - c0);
   endtask

   task automatic t_overflow();
      int b = ev_cnt;
      ev_ready = 1'b0;
      for (int i = 0; i < 5; i++) begin bus_start(); bus_stop(); end
      step(10);
      chk(ev_valid == 1'b1, "R10 held valid", ev_valid, 1);
      chk(ev_kind == 2'd0, "R10 held first kind", ev_kind, 0);
      chk(ovf_flag == 1'b1, "R11 overflow set", ovf_flag, 1);
      ev_ready = 1'b1; step(20);
      chk(ev_cnt - b == DEPTH, "R11 kept entries", ev_cnt - b, DEPTH);
      expect_ev(b,   2'd0, 8'h00, 1'b0, "R10 order first");
      expect_ev(b+7, 2'd2, 8'h00, 1'b0, "R10 order last");
      chk(ovf_flag == 1'b1, "R11 sticky after drain", ovf_flag, 1);
      ovf_clear = 1'b1; step(1); ovf_clear = 1'b0; step(2);
      chk(ovf_flag == 1'b0, "R11 cleared", ovf_flag, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      step(4);
      t_reset();
      t_byte();
      t_restart();
      t_low_toggle();
      t_glitch();
      t_abort();
      t_tight();
      t_time();
      t_overflow();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule